// File: doc/BRIEF.md
# Nonvolatile Array Write Status and Interrupt Controller

This block holds the control and status register for an on-chip nonvolatile data array. It follows a single array write from its start strobe to the done pulse that the high-voltage programming timer returns. It keeps a busy flag for the length of the write and raises a pending flag when the write finishes. Any array access, or any further start strobe, that arrives while the write is still running raises an illegal-access flag.

The CPU reads and writes the register through a byte-wide port, and reads are valid at any time. Software clears the two event flags once it has serviced them. Both event flags drive one interrupt request. That request is gated by a local enable bit in the register and by a global interrupt enable input. The busy flag takes no reset, so a write in flight is still reported after a reset.

Top module: `eer_status_ctrl`

## Requirements
- R1: While reset is held (active low), the enable bit 0, the illegal-access bit 2 and the pending bit 3 are cleared.
- R2: The busy bit 1 keeps its value across reset.
- R3: A write-start strobe while busy is clear sets busy one cycle later.
- R4: A write-done pulse while busy is set clears busy and sets pending one cycle later.
- R5: An array access strobe while busy is set sets illegal-access one cycle later. An access while busy is clear leaves illegal-access unchanged.
- R6: A write-start strobe while busy is set sets illegal-access and leaves busy set.
- R7: The interrupt request equals (pending OR illegal-access) AND enable AND global enable.
- R8: A software write loads bit 0 into enable and has no effect on busy.
- R9: A software write loads bit 2 into illegal-access and bit 3 into pending. A hardware set of either flag in the same cycle wins over a software clear.
- R10: Bits 7 to 4 always read as zero, whatever value is written to them. The register reads back the current state at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | CPU write strobe for the register |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read value |
| arr_access | input | 1 | Array read or write strobe, one cycle per access |
| wr_start | input | 1 | Array write start strobe |
| wr_done | input | 1 | Write-done pulse from the programming timer |
| gie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that a write-done pulse arrives only while a write is in flight. They also assume that strobes are single-cycle levels sampled on the rising clock edge. The rule that busy stays set after a colliding start strobe is checked only in cycles with no done pulse. The bench keeps to these assumptions: it raises done only after a matching start, and it drives every strobe on the falling edge for exactly one cycle. The one exception is a done pulse during the first reset, which brings the unreset busy flag to a known value before any property is enabled.

// File: rtl/eer_pkg.sv
// Package: shared register layout for the array status controller.
// Assumes a register at least four bits wide; the upper bits are reserved.
package eer_pkg;
    localparam int EN_BIT    = 0;
    localparam int BUSY_BIT  = 1;
    localparam int ILL_BIT   = 2;
    localparam int PEND_BIT  = 3;
    localparam int NUM_FLAGS = 2;   // illegal-access and pending
    localparam int USED_BITS = 4;

    // Bit position of event flag i (0 = illegal-access, 1 = pending).
    function automatic int flag_pos(input int i);
        return ILL_BIT + i;
    endfunction
endpackage

// File: rtl/eer_busy_track.sv
// Module: tracks an array write from its start strobe to its done pulse.
// Assumes: the busy flop has no reset, so its state survives a CPU reset;
// a done pulse while idle is ignored.
module eer_busy_track (
    input  logic clk,
    input  logic wr_start,
    input  logic wr_done,
    output logic busy,
    output logic done_evt,
    output logic clash_evt
);
    // Busy state: busy ends on done, idle begins a write on start.
    always_ff @(posedge clk) begin
        if (busy) busy <= ~wr_done;
        else      busy <= wr_start;
    end

    // Completion and collision events for the flag cells.
    assign done_evt  = busy & wr_done;
    assign clash_evt = busy & wr_start;
endmodule

// File: rtl/eer_flag_cell.sv
// Module: one event flag that hardware sets and software reads or writes.
// Assumes: a hardware set in the same cycle as a software write wins.
module eer_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic sw_wr,
    input  logic sw_val,
    output logic flag
);
    // Flag storage with hardware-set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (hw_set) flag <= 1'b1;
        else if (sw_wr)  flag <= sw_val;
    end
endmodule

// File: rtl/eer_irq_gate.sv
// Module: combines event flags into one gated interrupt request.
// Assumes: all sources are level flags held until software clears them.
module eer_irq_gate #(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic               en,
    input  logic               gie,
    output logic               irq
);
    // Any pending source, gated by both enables.
    assign irq = (|src) & en & gie;
endmodule

// File: rtl/eer_status_ctrl.sv
// Module: status and control register for a nonvolatile array writer.
// Assumes: reg_wr selects this register alone; reads are combinational.
module eer_status_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              arr_access,
    input  logic              wr_start,
    input  logic              wr_done,
    input  logic              gie,
    output logic              irq
);
    import eer_pkg::*;

    logic                 busy, done_evt, clash_evt, en;
    logic [NUM_FLAGS-1:0] hw_set_v, flag_v;

    eer_busy_track u_busy (
        .clk(clk), .wr_start(wr_start), .wr_done(wr_done),
        .busy(busy), .done_evt(done_evt), .clash_evt(clash_evt)
    );

    // Hardware sources: index 0 illegal access, index 1 completion.
    assign hw_set_v[0] = (busy & arr_access) | clash_evt;
    assign hw_set_v[1] = done_evt;

    generate
        for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
            eer_flag_cell u_cell (
                .clk(clk), .rst_n(rst_n), .hw_set(hw_set_v[i]),
                .sw_wr(reg_wr), .sw_val(reg_wdata[flag_pos(i)]),
                .flag(flag_v[i])
            );
        end
    endgenerate

    // Local interrupt enable, software writable only.
    always_ff @(posedge clk) begin
        if (!rst_n)      en <= 1'b0;
        else if (reg_wr) en <= reg_wdata[EN_BIT];
    end

    // Read view: reserved bits are held at zero.
    always_comb begin
        reg_rdata           = '0;
        reg_rdata[EN_BIT]   = en;
        reg_rdata[BUSY_BIT] = busy;
        for (int i = 0; i < NUM_FLAGS; i++)
            reg_rdata[flag_pos(i)] = flag_v[i];
    end

    eer_irq_gate #(.NUM_SRC(NUM_FLAGS)) u_irq (
        .src(flag_v), .en(en), .gie(gie), .irq(irq)
    );
endmodule

// File: rtl/eer_status_chk.sv
// Module: property checker bound to the status controller.
// Assumes: done pulses arrive only while a write is in flight.
module eer_status_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              arr_access,
    input logic              wr_start,
    input logic              wr_done,
    input logic              gie,
    input logic              irq
);
    assert_busy_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rdata[1] && wr_start) |=> reg_rdata[1]);
    assert_done_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && wr_done) |=> (!reg_rdata[1] && reg_rdata[3]));
    assert_access_ill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && arr_access) |=> reg_rdata[2]);
    assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[1] && wr_start && !wr_done) |=> (reg_rdata[1] && reg_rdata[2]));
    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (gie && reg_rdata[0] && (reg_rdata[2] || reg_rdata[3])));
    assert_busy_ro_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rdata[1] && !wr_start) |=> !reg_rdata[1]);
    assert_resv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:4] == '0);
endmodule

bind eer_status_ctrl eer_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .arr_access(arr_access), .wr_start(wr_start),
    .wr_done(wr_done), .gie(gie), .irq(irq)
);

// File: tb/sim_eer_status_ctrl.sv
module sim_eer_status_ctrl;
    logic       clk = 1'b0;
    logic       rst_n, reg_wr, arr_access, wr_start, wr_done, gie;
    logic [7:0] reg_wdata, reg_rdata;
    logic       irq;
    int         checks = 0, errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    eer_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .arr_access(arr_access), .wr_start(wr_start),
        .wr_done(wr_done), .gie(gie), .irq(irq)
    );

    // Fields: [21] wr, [20:13] wdata, [12] access, [11] start, [10] done,
    // [9] gie, [8:1] expected read value, [0] expected irq.
    localparam logic [21:0] VEC [18] = '{
        {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h03, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 8'h07, 1'b1},
        {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h09, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h09, 1'b0},
        {1'b1, 8'hF3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0},
        {1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0},
        {1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0C, 1'b0},
        {1'b1, 8'h0D, 1'b0, 1'b0, 1'b0, 1'b1, 8'h0D, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b1},
        {1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0},
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h07, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 8'h0D, 1'b1},
        {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 8'h0F, 1'b1},
        {1'b1, 8'h01, 1'b1, 1'b0, 1'b0, 1'b1, 8'h07, 1'b1},
        {1'b1, 8'h01, 1'b0, 1'b0, 1'b1, 1'b1, 8'h09, 1'b1},
        {1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:  return "R8 enable write";
            1:  return "R3 start sets busy";
            2:  return "R5 access while busy";
            3:  return "R9 sw clear illegal";
            4:  return "R4 done sets pending";
            5:  return "R7 global enable gate";
            6:  return "R10 reserved and R8 busy read-only";
            7:  return "R5 access while idle";
            8:  return "R9 sw set flags";
            9:  return "R7 local enable gate";
            10: return "R3 start again";
            11: return "R9 sw clear both";
            12: return "R6 start while busy";
            13: return "R4 done after clash";
            14: return "R3 start";
            15: return "R9 hw illegal wins";
            16: return "R9 hw pending wins";
            default: return "R9 sw clear all";
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_wr = 0; reg_wdata = 8'h00; arr_access = 0;
        wr_start = 0; wr_done = 0;
    endtask

    // Drive on the falling edge, sample 1 ns after the next rising edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; gie = 0; idle_inputs();
        wr_done = 1;                  // settle the unreset busy flop
        step();
        @(negedge clk); wr_done = 0;
        step();
        check("R1 reset state", reg_rdata, 8'h00);
        check("R7 irq at reset", {7'd0, irq}, 8'h00);
        @(negedge clk); rst_n = 1;

        for (int i = 0; i < 18; i++) begin
            @(negedge clk);
            reg_wr = VEC[i][21]; reg_wdata = VEC[i][20:13];
            arr_access = VEC[i][12]; wr_start = VEC[i][11];
            wr_done = VEC[i][10]; gie = VEC[i][9];
            step();
            check(vec_tag(i), reg_rdata, VEC[i][8:1]);
            check(vec_tag(i), {7'd0, irq}, {7'd0, VEC[i][0]});
        end

        // Busy survives reset while the other bits clear.
        @(negedge clk); idle_inputs(); reg_wr = 1; reg_wdata = 8'h0D;
        step();
        @(negedge clk); idle_inputs(); wr_start = 1;
        step();
        check("R3 start before reset", reg_rdata, 8'h0F);
        @(negedge clk); idle_inputs(); rst_n = 0;
        step();
        check("R2 busy kept and R1 others cleared", reg_rdata, 8'h02);
        @(negedge clk); rst_n = 1;
        step();
        check("R2 busy after release", reg_rdata, 8'h02);
        @(negedge clk); wr_done = 1;
        step();
        check("R4 done after reset", reg_rdata, 8'h08);
        check("R7 irq blocked by enable", {7'd0, irq}, 8'h00);

        // Software cannot set busy; reserved bits stay zero.
        @(negedge clk); idle_inputs(); reg_wr = 1; reg_wdata = 8'hFE;
        step();
        check("R8 busy read-only and R10 reserved", reg_rdata, 8'h0C);
        @(negedge clk); idle_inputs();
        step();
        check("R10 readback stable", reg_rdata, 8'h0C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule